// File: doc/BRIEF.md
# Burst Preamble and Header Framer

This block produces the unscrambled bit sequence that opens every transmitted burst. A rising edge on the transmit enable captures the mode select, the programmed sync length and the three header field values. The block then emits, one bit per bit slot, the sync run, the start-frame delimiter, the signal, service and length fields and a 16-bit header check word. Each bit is presented with a one-cycle valid strobe and a rate tag. The scrambler and modulator downstream use the tag to choose between 1 and 2 Mbps symbol handling.

Two preamble flavours are supported. The long flavour sends a run of ones and the delimiter 0xF3A0 starting from its least significant bit, with the whole header at 1 Mbps. The short flavour sends a run of zeros and the same delimiter reversed in time, with the header and check word at 2 Mbps. The bit slot length is a parameter counted in clock cycles. Once the last check bit has had its full slot, a ready flag tells the payload path it may start. The flag holds until the transmit enable is released. Dropping the enable at any earlier point abandons the burst.

Top module: `phy_hdr_framer`

## Requirements
- R1: A burst starts only on a low-to-high transition of `tx_en` seen in two consecutive clock samples. The first `bit_vld` strobe appears one cycle after the edge at which the high level is first sampled. An enable that is already high when reset releases starts nothing.
- R2: With `short_mode` = 0, the first `sync_len` bits are all 1.
- R3: With `short_mode` = 1, the first `sync_len` bits are all 0. A `sync_len` of 0 sends no sync bits in either mode.
- R4: The next 16 bits are the delimiter. In long mode they are bits 0 through 15 of 0xF3A0 in that order. In short mode they are bits 15 down to 0 of 0xF3A0.
- R5: The next 32 bits are `sig_field`, then `svc_field`, then `len_field`, each starting from bit 0.
- R6: `crc_out` equals the ones complement of the remainder of a CRC with polynomial 0x1021. The remainder is preset to 0xFFFF and fed with the 32 field bits in send order. Its 16 bits follow the fields on the serial output, bit 15 first.
- R7: Every bit is marked by a single-cycle `bit_vld` pulse. The next pulse comes BIT_CLKS cycles after a 1 Mbps bit and BIT_CLKS/2 cycles after a 2 Mbps bit.
- R8: `rate_2m` is 1 with a valid bit exactly when the mode is short and the bit belongs to the fields or the check word. Otherwise it is 0.
- R9: `hdr_done` rises one slot of the last check bit's rate after that bit's strobe. It stays high while `tx_en` stays high, and it is 0 from the cycle after `tx_en` is sampled low.
- R10: If `tx_en` is sampled low before `hdr_done`, no further `bit_vld` appears from the next cycle on and `hdr_done` stays 0. A later rising edge restarts from the first sync bit.
- R11: `bit_vld` and `hdr_done` are never high in the same cycle.
- R12: While reset is held, `bit_vld`, `bit_out`, `rate_2m` and `hdr_done` are 0 and `crc_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; rising edge starts a burst, low aborts or ends it |
| short_mode | input | 1 | 1 selects the short preamble flavour |
| sync_len | input | SYNC_W | Number of sync bits |
| sig_field | input | 8 | Signal field value |
| svc_field | input | 8 | Service field value |
| len_field | input | 16 | Length field value |
| bit_out | output | 1 | Serial bit, valid with `bit_vld` |
| bit_vld | output | 1 | One-cycle strobe per emitted bit |
| rate_2m | output | 1 | Rate tag of the current bit, 1 = 2 Mbps |
| hdr_done | output | 1 | Preamble and header complete; payload may start |
| crc_out | output | 16 | Complemented header check word |

## Verification
On every cycle, the assertions check that the strobe is a single-cycle pulse and that a low enable silences both the strobe and the ready flag from the next cycle on. They also check that ready persists while the enable stays high and that ready never coincides with a strobe. The bench scenarios are the only way to check the content of the stream. That covers the sync polarity per mode, the delimiter bit order, the field order, the check word value and its MSB-first placement. The scenarios also cover the exact slot spacing around the switch to 2 Mbps, the cycle at which ready rises, the zero-length sync case, and a clean restart after an abort.

// File: rtl/phy_hdr_pkg.sv
package phy_hdr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SYNC, PH_SFD, PH_FLD, PH_CRC, PH_TAIL, PH_DONE
  } phase_e;

  localparam logic [15:0] SFD_WORD  = 16'hF3A0;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam int          SFD_BITS  = 16;
  localparam int          CRC_BITS  = 16;
  localparam int          SIG_BITS  = 8;
  localparam int          SVC_BITS  = 8;
  localparam int          LEN_BITS  = 16;
  localparam int          FLD_BITS  = SIG_BITS + SVC_BITS + LEN_BITS;
endpackage

// File: rtl/hdr_crc16.sv
module hdr_crc16 #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic fb;
  assign fb = din ^ crc_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || init)
      crc_q <= '1;
    else if (shift)
      crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end
endmodule

// File: rtl/frm_pacer.sv
module frm_pacer #(
  parameter int BIT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rate2,
  output logic slot
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  assign slot = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (slot)
      cnt_q <= rate2 ? CW'(HALF - 1) : CW'(BIT_CLKS - 1);
    else
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/frm_bitsel.sv
module frm_bitsel
  import phy_hdr_pkg::*;
#(
  parameter int IW = 8
) (
  input  phase_e                phase,
  input  logic [IW-1:0]         idx,
  input  logic                  short_m,
  input  logic [FLD_BITS-1:0]   hdr_word,
  input  logic [CRC_BITS-1:0]   crc_q,
  output logic                  bit_o
);
  localparam int FW = $clog2(FLD_BITS);

  logic [SFD_BITS-1:0] sfd_rev;
  logic [CRC_BITS-1:0] crc_tx;

  for (genvar g = 0; g < SFD_BITS; g++) begin : g_sfd
    assign sfd_rev[g] = SFD_WORD[SFD_BITS-1-g];
  end
  for (genvar g = 0; g < CRC_BITS; g++) begin : g_crc
    assign crc_tx[g] = ~crc_q[CRC_BITS-1-g];
  end

  always_comb begin
    case (phase)
      PH_SYNC: bit_o = ~short_m;
      PH_SFD:  bit_o = short_m ? sfd_rev[idx[3:0]] : SFD_WORD[idx[3:0]];
      PH_FLD:  bit_o = hdr_word[idx[FW-1:0]];
      PH_CRC:  bit_o = crc_tx[idx[3:0]];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/phy_hdr_framer.sv
module phy_hdr_framer
  import phy_hdr_pkg::*;
#(
  parameter int BIT_CLKS = 4,
  parameter int SYNC_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_en,
  input  logic                short_mode,
  input  logic [SYNC_W-1:0]   sync_len,
  input  logic [SIG_BITS-1:0] sig_field,
  input  logic [SVC_BITS-1:0] svc_field,
  input  logic [LEN_BITS-1:0] len_field,
  output logic                bit_out,
  output logic                bit_vld,
  output logic                rate_2m,
  output logic                hdr_done,
  output logic [CRC_BITS-1:0] crc_out
);
  localparam int FW = $clog2(FLD_BITS);
  localparam int IW = (SYNC_W > FW) ? SYNC_W : FW;

  phase_e              ph_q, ph_nx;
  logic [IW-1:0]       idx_q;
  logic                en_q, short_q;
  logic [SYNC_W-1:0]   slen_q;
  logic [FLD_BITS-1:0] hdr_q;
  logic [CRC_BITS-1:0] crc_q;
  logic                start, run, rate2, slot, cur_bit, last;

  assign start = tx_en && !en_q && (ph_q == PH_IDLE);
  assign run   = ph_q inside {PH_SYNC, PH_SFD, PH_FLD, PH_CRC, PH_TAIL};
  assign rate2 = short_q && (ph_q == PH_FLD || ph_q == PH_CRC);

  always_comb begin
    last  = 1'b0;
    ph_nx = ph_q;
    case (ph_q)
      PH_SYNC: begin last = (idx_q == IW'(slen_q - 1'b1));    ph_nx = PH_SFD;  end
      PH_SFD:  begin last = (idx_q == IW'(SFD_BITS - 1));     ph_nx = PH_FLD;  end
      PH_FLD:  begin last = (idx_q == IW'(FLD_BITS - 1));     ph_nx = PH_CRC;  end
      PH_CRC:  begin last = (idx_q == IW'(CRC_BITS - 1));     ph_nx = PH_TAIL; end
      default: begin last = 1'b0;                             ph_nx = ph_q;    end
    endcase
  end

  frm_pacer #(.BIT_CLKS(BIT_CLKS)) i_pacer (
    .clk(clk), .rst(rst), .run(run), .rate2(rate2), .slot(slot)
  );

  frm_bitsel #(.IW(IW)) i_bitsel (
    .phase(ph_q), .idx(idx_q), .short_m(short_q),
    .hdr_word(hdr_q), .crc_q(crc_q), .bit_o(cur_bit)
  );

  hdr_crc16 #(.W(CRC_BITS), .POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst(rst), .init(start),
    .shift(slot && ph_q == PH_FLD), .din(cur_bit), .crc_q(crc_q)
  );

  assign crc_out = ~crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      idx_q    <= '0;
      en_q     <= 1'b1;
      short_q  <= 1'b0;
      slen_q   <= '0;
      hdr_q    <= '0;
      bit_out  <= 1'b0;
      bit_vld  <= 1'b0;
      rate_2m  <= 1'b0;
      hdr_done <= 1'b0;
    end else begin
      en_q    <= tx_en;
      bit_vld <= 1'b0;
      if (start) begin
        short_q <= short_mode;
        slen_q  <= sync_len;
        hdr_q   <= {len_field, svc_field, sig_field};
        idx_q   <= '0;
        ph_q    <= (sync_len == '0) ? PH_SFD : PH_SYNC;
      end else if (ph_q != PH_IDLE && !tx_en) begin
        ph_q     <= PH_IDLE;
        hdr_done <= 1'b0;
      end else if (slot) begin
        if (ph_q == PH_TAIL) begin
          ph_q     <= PH_DONE;
          hdr_done <= 1'b1;
        end else begin
          bit_out <= cur_bit;
          bit_vld <= 1'b1;
          rate_2m <= rate2;
          if (last) begin
            idx_q <= '0;
            ph_q  <= ph_nx;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/phy_hdr_framer_chk.sv
module phy_hdr_framer_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic bit_vld,
  input logic hdr_done
);
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !bit_vld);

  assert_done_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !hdr_done);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && tx_en) |=> hdr_done);

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(bit_vld && hdr_done));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);
endmodule

bind phy_hdr_framer phy_hdr_framer_chk i_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .bit_vld(bit_vld), .hdr_done(hdr_done)
);

// File: tb/test_phy_hdr_framer.sv
module test_phy_hdr_framer;
  localparam int BIT_CLKS = 4;
  localparam int HALF     = BIT_CLKS / 2;
  localparam logic [15:0] DLM = 16'hF3A0;
  // {short, sync_len, sig, svc, len}
  localparam logic [40:0] VECS [0:3] = '{
    {1'b0, 8'd128, 8'h0A, 8'h00, 16'h0070},
    {1'b1, 8'd56,  8'h14, 8'h04, 16'h01F3},
    {1'b0, 8'd8,   8'h6E, 8'h80, 16'hABCD},
    {1'b1, 8'd0,   8'hFF, 8'h5A, 16'h1234}
  };

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, short_mode = 1'b0;
  logic [7:0]  sync_len = '0, sig_field = '0, svc_field = '0;
  logic [15:0] len_field = '0;
  logic bit_out, bit_vld, rate_2m, hdr_done;
  logic [15:0] crc_out;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_hdr_framer #(.BIT_CLKS(BIT_CLKS), .SYNC_W(8)) i_phy_hdr_framer (
    .clk(clk), .rst(rst), .tx_en(tx_en), .short_mode(short_mode),
    .sync_len(sync_len), .sig_field(sig_field), .svc_field(svc_field),
    .len_field(len_field), .bit_out(bit_out), .bit_vld(bit_vld),
    .rate_2m(rate_2m), .hdr_done(hdr_done), .crc_out(crc_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] w);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb;
      fb = w[i] ^ r[15];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return ~r;
  endfunction

  task automatic run_frame(input logic [40:0] v);
    logic got_b [0:511];
    logic got_r [0:511];
    int   got_c [0:511];
    int nb = 0, done_c = -1, t0, sl, n_exp, e_sync = 0, e_sfd = 0, e_fld = 0, e_crc = 0, e_rate = 0, e_gap = 0;
    logic sh;
    logic [31:0] hw;
    logic [15:0] c;
    sh = v[40]; sl = int'(v[39:32]);
    hw = {v[15:0], v[23:16], v[31:24]};
    c  = ref_crc(hw);
    n_exp = sl + 64;
    @(negedge clk);
    short_mode = sh; sync_len = v[39:32]; sig_field = v[31:24];
    svc_field = v[23:16]; len_field = v[15:0]; tx_en = 1'b1; t0 = cyc;
    for (int w = 0; w < 4000 && done_c < 0; w++) begin
      @(negedge clk);
      if (bit_vld && nb < 512) begin
        got_b[nb] = bit_out; got_r[nb] = rate_2m; got_c[nb] = cyc; nb++;
      end
      if (hdr_done) done_c = cyc;
    end
    chk(sh ? "R3 bit count" : "R2 bit count", nb, n_exp);
    chk("R1 first strobe cycle", nb > 0 ? got_c[0] : -1, t0 + 2);
    if (nb == n_exp) begin
      for (int k = 0; k < n_exp; k++) begin
        logic eb;
        int j;
        if (k < sl) begin eb = !sh; if (got_b[k] != eb) e_sync++; end
        else if (k < sl + 16) begin
          j = k - sl; eb = sh ? DLM[15 - j] : DLM[j]; if (got_b[k] != eb) e_sfd++;
        end else if (k < sl + 48) begin
          j = k - sl - 16; if (got_b[k] != hw[j]) e_fld++;
        end else begin
          j = k - sl - 48; if (got_b[k] != c[15 - j]) e_crc++;
        end
        if (got_r[k] != (sh && k >= sl + 16)) e_rate++;
        if (k < n_exp - 1 && (got_c[k+1] - got_c[k]) != (got_r[k] ? HALF : BIT_CLKS)) e_gap++;
      end
      chk(sh ? "R3 sync bit errors" : "R2 sync bit errors", e_sync, 0);
      chk("R4 delimiter bit errors", e_sfd, 0);
      chk("R5 field bit errors", e_fld, 0);
      chk("R6 check bit errors", e_crc, 0);
      chk("R8 rate tag errors", e_rate, 0);
      chk("R7 spacing errors", e_gap, 0);
      chk("R9 ready cycle", done_c, got_c[n_exp-1] + (sh ? HALF : BIT_CLKS));
    end
    chk("R6 crc_out", int'(crc_out), int'(c));
    repeat (3) @(negedge clk);
    chk("R9 ready held", int'(hdr_done), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R9 ready drop", int'(hdr_done), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic abort_after(input logic sh, input logic [7:0] sl, input int wait_c);
    int seen = 0, rdy = 0;
    @(negedge clk);
    short_mode = sh; sync_len = sl; sig_field = 8'h3C; svc_field = 8'h00; len_field = 16'h0100;
    tx_en = 1'b1;
    repeat (wait_c) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bit_vld) seen++;
      if (hdr_done) rdy++;
    end
    chk("R10 strobes after abort", seen, 0);
    chk("R10 ready after abort", rdy, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int spurious = 0;
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset bit_vld", int'(bit_vld), 0);
    chk("R12 reset hdr_done", int'(hdr_done), 0);
    chk("R12 reset rate_2m", int'(rate_2m), 0);
    chk("R12 reset bit_out", int'(bit_out), 0);
    chk("R12 reset crc_out", int'(crc_out), 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bit_vld) spurious++;
    end
    chk("R1 no start on held enable", spurious, 0);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);

    for (int vi = 0; vi < 4; vi++) run_frame(VECS[vi]);

    abort_after(1'b0, 8'd128, 40);   // R10 abort in sync
    run_frame(VECS[1]);              // R10 restart from first sync bit
    abort_after(1'b1, 8'd0, 80);     // R10 abort inside header fields
    run_frame(VECS[2]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule